// File: doc/BRIEF.md
# Crate Busy and Token Manager

This block sits in the switch slot of a crate and serves its payload slots, 16 by default. It merges the busy lines of the participating payloads into one registered crate busy for the upstream trigger logic. It keeps a saturating busy-cycle counter for every slot. It circulates a single readout token among the participating slots. It also watches the payload trigger-out lines for a programmed pattern and raises a one-clock intra-crate trigger when that pattern appears.

Software reaches the block through a plain register port. Writes take effect on the clock edge on which `reg_we` is high. Reads are combinational from `reg_addr`. One enable mask selects which slots take part, and that mask serves both the crate busy and the token ring. A second mask and a pattern value define the trigger match.

Top module: `crate_busy_token`

## Requirements
- R1: After reset, `crate_busy`, `token_grant` and `trig_pulse` are 0. The slot enable and trigger mask registers read 0, the pattern register reads all ones in its low NSLOT bits, and every counter reads 0.
- R2: `crate_busy` is high exactly one cycle after any slot has both its busy line high and its enable bit set. Busy lines of disabled slots have no effect on it.
- R3: Counter i adds one on every clock edge where `busy_in[i]` is high, whatever the enable mask holds. It reads at address 32+i.
- R4: A counter stops at 2^CNT_W-1 and holds that value while busy stays high.
- R5: A write of any data to address 32+i clears counter i. A clear wins over an increment in the same cycle.
- R6: While no token is held, the token goes on the next edge to the lowest-numbered enabled slot, and `token_grant` becomes one-hot on that slot. With no slot enabled, `token_grant` stays 0.
- R7: When the holder raises its `token_ret` bit, the token moves on the next edge to the next enabled slot in ascending order. Slot NSLOT-1 wraps to slot 0, and a sole enabled slot keeps the token. `token_ret` bits from slots that do not hold the token are ignored.
- R8: If the holder's enable bit is cleared, `token_grant` drops to 0 on the next edge. R6 then applies.
- R9: `trig_pulse` is high for one cycle, one edge after (trig_in AND mask) becomes equal to the pattern having been unequal. It stays low while the match persists.
- R10: Address 0 is the slot enable mask (bit i = slot i takes part). Address 1 is the trigger mask. Address 2 is the trigger pattern. All three use data bits NSLOT-1:0 and read back. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_in | input | NSLOT | Busy line of each payload slot |
| trig_in | input | NSLOT | Trigger-out line of each payload slot |
| token_ret | input | NSLOT | Token return, one bit per slot |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| crate_busy | output | 1 | Merged busy of enabled slots |
| token_grant | output | NSLOT | One-hot token holder, 0 when idle |
| trig_pulse | output | 1 | One-clock pattern trigger |

## Verification
Two collisions matter in this block. The first is a software clear and a busy increment landing on the same counter in the same edge. The bench provokes it by holding a slot busy while it writes that slot's counter address, and it expects a read of 0 right after. The second is an enable-mask write that removes the slot currently holding the token. The bench judges it cycle by cycle: the token is still shown for one cycle, then the grant is empty, then the token is reacquired by the lowest remaining enabled slot.

// File: rtl/crate_busy_token.sv
module crate_busy_token #(
  parameter int NSLOT = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] busy_in,
  input  logic [NSLOT-1:0] trig_in,
  input  logic [NSLOT-1:0] token_ret,
  input  logic             reg_we,
  input  logic [5:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             crate_busy,
  output logic [NSLOT-1:0] token_grant,
  output logic             trig_pulse
);
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [NSLOT-1:0] slot_en, trig_mask, trig_pat;
  logic [CNT_W-1:0] cnt [NSLOT];
  logic             tok_v;
  logic [IW-1:0]    tok_i;
  logic             match, match_q;

  function automatic logic [IW-1:0] next_slot(input logic [IW-1:0] from,
                                              input logic [NSLOT-1:0] en);
    logic [IW-1:0] r;
    r = from;
    for (int k = NSLOT; k >= 1; k--) begin
      if (en[(int'(from) + k) % NSLOT]) r = IW'((int'(from) + k) % NSLOT);
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_en   <= '0;
      trig_mask <= '0;
      trig_pat  <= '1;
    end else if (reg_we) begin
      if (reg_addr == 6'd0) slot_en   <= reg_wdata[NSLOT-1:0];
      if (reg_addr == 6'd1) trig_mask <= reg_wdata[NSLOT-1:0];
      if (reg_addr == 6'd2) trig_pat  <= reg_wdata[NSLOT-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crate_busy <= 1'b0;
    else        crate_busy <= |(busy_in & slot_en);
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_cnt
    logic clr;
    assign clr = reg_we && (reg_addr == 6'(32 + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt[i] <= '0;
      else if (clr)                      cnt[i] <= '0;
      else if (busy_in[i] && cnt[i] != CMAX) cnt[i] <= cnt[i] + 1'b1;
    end

    a_r3_count: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_in[i] && !clr && cnt[i] != CMAX) |=> cnt[i] == $past(cnt[i]) + 1'b1);
    a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[i] == CMAX && !clr) |=> cnt[i] == CMAX);
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt[i] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_v <= 1'b0;
      tok_i <= '0;
    end else if (tok_v && !slot_en[tok_i]) begin
      tok_v <= 1'b0;
    end else if (tok_v && token_ret[tok_i]) begin
      tok_i <= next_slot(tok_i, slot_en);
    end else if (!tok_v && |slot_en) begin
      tok_v <= 1'b1;
      tok_i <= next_slot(IW'(NSLOT - 1), slot_en);
    end
  end

  assign token_grant = tok_v ? (NSLOT'(1) << tok_i) : '0;

  assign match = ((trig_in & trig_mask) == trig_pat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q    <= 1'b0;
      trig_pulse <= 1'b0;
    end else begin
      match_q    <= match;
      trig_pulse <= match && !match_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 6'd0) reg_rdata = 32'(slot_en);
    if (reg_addr == 6'd1) reg_rdata = 32'(trig_mask);
    if (reg_addr == 6'd2) reg_rdata = 32'(trig_pat);
    for (int i = 0; i < NSLOT; i++)
      if (reg_addr == 6'(32 + i)) reg_rdata = 32'(cnt[i]);
  end

  a_r2_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    |(busy_in & slot_en) |=> crate_busy);
  a_r2_busy_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(busy_in & slot_en)) |=> !crate_busy);
  a_r6_acquire: assert property (@(posedge clk) disable iff (!rst_n)
    (token_grant == '0 && |slot_en) |=> |token_grant);
  a_r6_one_holder: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(token_grant));
  a_r7_pass_on: assert property (@(posedge clk) disable iff (!rst_n)
    (|(token_grant & token_ret) && |(token_grant & slot_en)) |=> |(token_grant & slot_en));
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (|token_grant && !(|(token_grant & slot_en))) |=> token_grant == '0);
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);
endmodule

// File: tb/crate_busy_token_bench.sv
module crate_busy_token_bench;
  localparam int NSLOT = 16;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSLOT-1:0] busy_in = '0, trig_in = '0, token_ret = '0;
  logic             reg_we = 1'b0;
  logic [5:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             crate_busy, trig_pulse;
  logic [NSLOT-1:0] token_grant;

  crate_busy_token #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_crate_busy_token (
    .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .trig_in(trig_in),
    .token_ret(token_ret), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .crate_busy(crate_busy),
    .token_grant(token_grant), .trig_pulse(trig_pulse));

  always #10 clk = ~clk;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic expect_out(int sel, logic [31:0] exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        case (it.sel)
          0: got = reg_rdata;
          1: got = 32'(token_grant);
          2: got = 32'(crate_busy);
          default: got = 32'(trig_pulse);
        endcase
        n_run++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    // R1 reset state
    reg_addr = 6'd0;
    expect_out(1, 0, "R1"); expect_out(2, 0, "R1"); expect_out(3, 0, "R1");
    expect_out(0, 0, "R1");
    tick();
    reg_addr = 6'd2; expect_out(0, 32'h0000_FFFF, "R1"); tick();
    reg_addr = 6'd32; expect_out(0, 0, "R1"); tick();
    // R6 no slot enabled: token stays idle
    expect_out(1, 0, "R6"); tick();
    // R6 enable slots 2 and 5
    expect_out(1, 0, "R6");
    wr(6'd0, 32'h0000_0024);
    expect_out(1, 32'h4, "R6"); tick();
    // R7 return from non-holder ignored
    token_ret = 16'h0020; expect_out(1, 32'h4, "R7"); tick();
    token_ret = 16'h0004; expect_out(1, 32'h20, "R7"); tick();
    token_ret = 16'h0020; expect_out(1, 32'h4, "R7 wrap"); tick();
    token_ret = '0; expect_out(1, 32'h4, "R7 hold"); tick();
    // R2 crate busy
    busy_in = 16'h0008; expect_out(2, 0, "R2 disabled slot"); tick();
    busy_in = 16'h0020; expect_out(2, 1, "R2"); tick();
    busy_in = '0; expect_out(2, 0, "R2"); tick();
    // R8 holder (slot 2) disabled
    expect_out(1, 32'h4, "R8");
    wr(6'd0, 32'h0000_0020);
    expect_out(1, 0, "R8"); tick();
    expect_out(1, 32'h20, "R8"); tick();
    // R7 sole enabled slot keeps the token
    token_ret = 16'h0020; expect_out(1, 32'h20, "R7 sole"); tick();
    token_ret = '0; tick();
    // R3 count seven busy cycles on slot 4 (disabled)
    busy_in = 16'h0010;
    for (int k = 0; k < 7; k++) tick();
    busy_in = '0; reg_addr = 6'd36;
    expect_out(0, 7, "R3"); tick();
    // R5 clear collides with increment
    busy_in = 16'h0010; reg_we = 1'b1; reg_addr = 6'd36; reg_wdata = 32'h1234;
    expect_out(0, 0, "R5"); tick();
    reg_we = 1'b0; busy_in = '0;
    expect_out(0, 0, "R5"); tick();
    // R4 saturation on slot 6
    busy_in = 16'h0040;
    for (int k = 0; k < 300; k++) tick();
    busy_in = '0; reg_addr = 6'd38;
    expect_out(0, 255, "R4"); tick();
    busy_in = 16'h0040; expect_out(0, 255, "R4"); tick();
    busy_in = '0; tick();
    // R9 pattern trigger
    wr(6'd1, 32'h0000_00F0);
    wr(6'd2, 32'h0000_0030);
    trig_in = 16'h0030; expect_out(3, 1, "R9"); tick();
    expect_out(3, 0, "R9 held"); tick();
    trig_in = 16'h0130; expect_out(3, 0, "R9 masked bit"); tick();
    trig_in = 16'h0010; expect_out(3, 0, "R9 mismatch"); tick();
    trig_in = 16'h8030; expect_out(3, 1, "R9 new match"); tick();
    expect_out(3, 0, "R9"); tick();
    trig_in = '0; tick();
    // R10 register readback
    reg_addr = 6'd1; expect_out(0, 32'h00F0, "R10"); tick();
    reg_addr = 6'd0; expect_out(0, 32'h0020, "R10"); tick();
    reg_addr = 6'd5; expect_out(0, 0, "R10"); tick();
    tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule